// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading up to two table entries from memory. A client hands it a virtual address together with the base of the top-level table on a valid/ready channel. The block issues single-word reads on a request/response memory port, decodes each returned entry, and ends with either a physical address or a fault. The result is held on a second valid/ready channel until it is taken.

Bit 2 of every entry marks it as present. Bits [1:0] give its type. At the first level the type selects one of three things: a second-level table aligned to 4 KB, a second-level table aligned to 1 KB, or a 4 MB leaf mapping. The fourth code is invalid. At the second level the type selects a 4 KB, 16 KB or 64 KB page, and the fourth code is invalid. The physical address is built from the frame bits of the entry above the mask and the virtual address bits below the mask.

Only one walk is in flight at a time. A synchronous reset abandons any walk, and any memory response still outstanding at that point is ignored.

Top module: `xlat_walker`

## Requirements
- R1: During and right after reset, `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: The first read goes to `req_tbl_base + 4*va[31:22]`. While `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` hold steady.
- R3: If entry bit 2 (present) is 0, the walk ends in a fault. `rsp_fault_lvl` is 1 when this happens at the first level and 2 when it happens at the second level.
- R4: First-level type 2 faults with level 1. Second-level type 3 faults with level 2. An invalid first-level entry costs exactly one read.
- R5: First-level type 3 with present set is a 4 MB mapping. The result is `pa = (e & 0xFFC00000) | (va & 0x003FFFFF)` with size code 3.
- R6: First-level type 0 makes the second read go to `(e & 0xFFFFF000) + 4*va[21:12]`.
- R7: First-level type 1 makes the second read go to `(e & 0xFFFFFC00) + 4*va[21:14]`.
- R8: Second-level types 0, 1 and 2 map 4 KB, 16 KB and 64 KB pages, using masks 0xFFFFF000, 0xFFFF C000 and 0xFFFF0000 and size codes 0, 1 and 2. The result is `pa = (e & mask) | (va & ~mask)`.
- R9: `req_ready` is 1 only while idle. A result stays valid and unchanged until `rsp_ready`; the walker is idle in the cycle after the result is taken.
- R10: A 4 MB mapping completes after one memory read. Any other successful mapping completes after two reads.
- R11: A response that arrives after a reset in the middle of a walk produces no result and no new read.
- R12: A fault result carries `rsp_pa` = 0 and `rsp_size` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_tbl_base | input | 32 | Base address of the first-level table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry returned by memory |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pa | output | 32 | Physical address, or 0 on fault |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_lvl | output | 2 | Level of the faulting entry (1 or 2) |
| rsp_size | output | 2 | Page size code: 0=4 KB, 1=16 KB, 2=64 KB, 3=4 MB |

## Verification
The bench sweeps every combination of the present bit and the type code at both levels, across several virtual addresses that include all-zeros and all-ones. It also varies memory stall and latency. A walker that shifted the second-level index by a fixed amount would issue a wrong second read for 1 KB tables. A walker that swapped an invalid code for a valid one would return a mapping where a fault is expected, or would read one entry too many. Results are held under back-pressure so that an early drop or a change of data is caught. A reset is placed between a read and its response, so a design that consumed the stale data would raise a spurious result.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
   } walk_st_e;

   typedef enum logic [1:0] {
      PG_4K = 2'd0, PG_16K = 2'd1, PG_64K = 2'd2, PG_4M = 2'd3
   } pg_size_e;

   typedef enum logic [1:0] {
      ACT_FAULT, ACT_NEXT, ACT_LEAF
   } ent_act_e;

   localparam int unsigned PRESENT_BIT = 2;
   // number of low zero bits in each mask
   localparam int unsigned LOW_TBL4K  = 12;
   localparam int unsigned LOW_TBL1K  = 10;
   localparam int unsigned LOW_SUPER  = 22;
   localparam int unsigned LOW_PG4K   = 12;
   localparam int unsigned LOW_PG16K  = 14;
   localparam int unsigned LOW_PG64K  = 16;
endpackage

// File: rtl/xlat_decode.sv
module xlat_decode
   import xlat_pkg::*;
#(
   parameter int unsigned LEVEL = 1,
   parameter int unsigned AW    = 32
) (
   input  logic [2:0]    entry_lo,
   output ent_act_e      act,
   output logic [AW-1:0] mask,
   output pg_size_e      size
);
   localparam logic [AW-1:0] ONES = {AW{1'b1}};

   logic       present;
   logic [1:0] kind;
   assign present = entry_lo[PRESENT_BIT];
   assign kind    = entry_lo[1:0];

   generate
      if (LEVEL == 1) begin : g_top
         always_comb begin
            act  = ACT_FAULT;
            mask = '0;
            size = PG_4K;
            if (present) begin
               unique case (kind)
                  2'd0: begin act = ACT_NEXT; mask = ONES << LOW_TBL4K; end
                  2'd1: begin act = ACT_NEXT; mask = ONES << LOW_TBL1K; end
                  2'd3: begin act = ACT_LEAF; mask = ONES << LOW_SUPER; size = PG_4M; end
                  default: act = ACT_FAULT;
               endcase
            end
         end
      end else if (LEVEL == 2) begin : g_leaf
         always_comb begin
            act  = ACT_FAULT;
            mask = '0;
            size = PG_4K;
            if (present) begin
               unique case (kind)
                  2'd0: begin act = ACT_LEAF; mask = ONES << LOW_PG4K;  size = PG_4K;  end
                  2'd1: begin act = ACT_LEAF; mask = ONES << LOW_PG16K; size = PG_16K; end
                  2'd2: begin act = ACT_LEAF; mask = ONES << LOW_PG64K; size = PG_64K; end
                  default: act = ACT_FAULT;
               endcase
            end
         end
      end else begin : g_bad_level
         $error("xlat_decode: LEVEL must be 1 or 2");
      end
   endgenerate
endmodule

// File: rtl/xlat_l2_index.sv
module xlat_l2_index #(
   parameter int unsigned AW       = 32,
   parameter int unsigned L1_IDX_W = 10
) (
   input  logic [AW-1:0] l1_entry,
   input  logic [AW-1:0] mask,
   input  logic [AW-1:0] va,
   output logic [AW-1:0] l2_addr
);
   logic [AW-1:0] idx;

   always_comb begin
      int   run;
      logic stop;
      run  = 0;
      stop = 1'b0;
      for (int i = AW - 1; i >= 0; i--) begin
         if (!stop && mask[i]) run = run + 1;
         else stop = 1'b1;
      end
      // drop the level-one index bits, then align by the table span
      idx     = (va << L1_IDX_W) >> (run + 2);
      l2_addr = (l1_entry & mask) + (idx << 2);
   end
endmodule

// File: rtl/xlat_merge.sv
module xlat_merge #(
   parameter int unsigned AW = 32
) (
   input  logic [AW-1:0] entry,
   input  logic [AW-1:0] va,
   input  logic [AW-1:0] mask,
   output logic [AW-1:0] pa
);
   assign pa = (entry & mask) | (va & ~mask);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xlat_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned L1_IDX_W = 10
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_va,
   input  logic [AW-1:0] req_tbl_base,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid,
   input  logic [AW-1:0] mem_rsp_data,
   output logic          rsp_valid,
   input  logic          rsp_ready,
   output logic [AW-1:0] rsp_pa,
   output logic          rsp_fault,
   output logic [1:0]    rsp_fault_lvl,
   output logic [1:0]    rsp_size
);
   localparam int unsigned PAD_W = AW - L1_IDX_W - 2;

   generate
      if (AW != 32) begin : g_bad_aw
         $error("xlat_walker: AW must be 32");
      end
      if (L1_IDX_W + LOW_SUPER != AW) begin : g_bad_idx
         $error("xlat_walker: L1_IDX_W must cover the bits above the super page");
      end
   endgenerate

   walk_st_e      state;
   logic [AW-1:0] va_q, addr_q, pa_q;
   logic          fault_q;
   logic [1:0]    lvl_q, size_q;

   ent_act_e      d1_act, d2_act;
   logic [AW-1:0] d1_mask, d2_mask, sel_mask, merged_pa, l2_addr, l1_addr;
   pg_size_e      d1_size, d2_size;

   assign l1_addr = req_tbl_base + {{PAD_W{1'b0}}, req_va[AW-1 -: L1_IDX_W], 2'b00};

   xlat_decode #(.LEVEL(1), .AW(AW)) i_dec1 (
      .entry_lo(mem_rsp_data[2:0]), .act(d1_act), .mask(d1_mask), .size(d1_size)
   );
   xlat_decode #(.LEVEL(2), .AW(AW)) i_dec2 (
      .entry_lo(mem_rsp_data[2:0]), .act(d2_act), .mask(d2_mask), .size(d2_size)
   );
   xlat_l2_index #(.AW(AW), .L1_IDX_W(L1_IDX_W)) i_l2idx (
      .l1_entry(mem_rsp_data), .mask(d1_mask), .va(va_q), .l2_addr(l2_addr)
   );

   assign sel_mask = (state == ST_L2_WAIT) ? d2_mask : d1_mask;

   xlat_merge #(.AW(AW)) i_merge (
      .entry(mem_rsp_data), .va(va_q), .mask(sel_mask), .pa(merged_pa)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         va_q    <= '0;
         addr_q  <= '0;
         pa_q    <= '0;
         fault_q <= 1'b0;
         lvl_q   <= 2'd0;
         size_q  <= 2'd0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_va;
                  addr_q <= l1_addr;
                  state  <= ST_L1_REQ;
               end
            end
            ST_L1_REQ: if (mem_req_ready) state <= ST_L1_WAIT;
            ST_L2_REQ: if (mem_req_ready) state <= ST_L2_WAIT;
            ST_L1_WAIT: begin
               if (mem_rsp_valid) begin
                  unique case (d1_act)
                     ACT_NEXT: begin
                        addr_q <= l2_addr;
                        state  <= ST_L2_REQ;
                     end
                     ACT_LEAF: begin
                        pa_q    <= merged_pa;
                        fault_q <= 1'b0;
                        lvl_q   <= 2'd0;
                        size_q  <= d1_size;
                        state   <= ST_DONE;
                     end
                     default: begin
                        pa_q    <= '0;
                        fault_q <= 1'b1;
                        lvl_q   <= 2'd1;
                        size_q  <= 2'd0;
                        state   <= ST_DONE;
                     end
                  endcase
               end
            end
            ST_L2_WAIT: begin
               if (mem_rsp_valid) begin
                  state <= ST_DONE;
                  if (d2_act == ACT_LEAF) begin
                     pa_q    <= merged_pa;
                     fault_q <= 1'b0;
                     lvl_q   <= 2'd0;
                     size_q  <= d2_size;
                  end else begin
                     pa_q    <= '0;
                     fault_q <= 1'b1;
                     lvl_q   <= 2'd2;
                     size_q  <= 2'd0;
                  end
               end
            end
            ST_DONE: if (rsp_ready) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == ST_IDLE);
   assign mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
   assign mem_req_addr  = addr_q;
   assign rsp_valid     = (state == ST_DONE);
   assign rsp_pa        = pa_q;
   assign rsp_fault     = fault_q;
   assign rsp_fault_lvl = lvl_q;
   assign rsp_size      = size_q;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst,
   input logic          req_valid,
   input logic          req_ready,
   input logic          mem_req_valid,
   input logic          mem_req_ready,
   input logic [AW-1:0] mem_req_addr,
   input logic          rsp_valid,
   input logic          rsp_ready,
   input logic [AW-1:0] rsp_pa,
   input logic          rsp_fault,
   input logic [1:0]    rsp_fault_lvl,
   input logic [1:0]    rsp_size
);
   logic [1:0] rd_cnt;

   always_ff @(posedge clk) begin
      if (rst) rd_cnt <= 2'd0;
      else if (req_valid && req_ready) rd_cnt <= 2'd0;
      else if (mem_req_valid && mem_req_ready && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
   end

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (req_ready && !mem_req_valid && !rsp_valid)); // R1
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R2
   AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_fault) |-> (rsp_fault_lvl == 2'd1 || rsp_fault_lvl == 2'd2)); // R3
   AST_L1_FAULT_ONE_READ: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_fault && rsp_fault_lvl == 2'd1) |-> (rd_cnt == 2'd1)); // R4
   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)
                                     && $stable(rsp_fault_lvl) && $stable(rsp_size))); // R9
   AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (!mem_req_valid && !rsp_valid)); // R9
   AST_SUPER_ONE_READ: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !rsp_fault && rsp_size == 2'd3) |-> (rd_cnt == 2'd1)); // R10
   AST_PAGE_TWO_READS: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !rsp_fault && rsp_size != 2'd3) |-> (rd_cnt == 2'd2)); // R10
   AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && rsp_size == 2'd0)); // R12
endmodule

bind xlat_walker xlat_walker_chk #(.AW(AW)) i_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
   .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
   .rsp_size(rsp_size)
);

// File: tb/test_xlat_walker.sv
module test_xlat_walker;
   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid, req_ready;
   logic [31:0] req_va, req_tbl_base;
   logic        mem_req_valid, mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        rsp_valid, rsp_ready;
   logic [31:0] rsp_pa;
   logic        rsp_fault;
   logic [1:0]  rsp_fault_lvl, rsp_size;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   logic [31:0] lcg = 32'h1234_5678;

   always #10 clk = ~clk;

   xlat_walker i_xlat_walker (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_tbl_base(req_tbl_base),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
      .rsp_size(rsp_size)
   );

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] next_rand();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg;
   endfunction

   task automatic walk(input logic [31:0] va, input logic [31:0] base,
                       input logic [31:0] e1, input logic [31:0] e2,
                       input int stall, input int lat);
      logic [31:0] a1, a2, m, exp_pa, hold_pa;
      logic [1:0]  exp_size, exp_lvl;
      logic        exp_fault;
      int          exp_reads, reads, guard;
      string       tag;
      a1 = base + {20'd0, va[31:22], 2'b00};
      a2 = '0; exp_pa = '0; exp_size = 2'd0; exp_lvl = 2'd0; exp_fault = 1'b0;
      exp_reads = 1; tag = "R5";
      if (!e1[2] || e1[1:0] == 2'd2) begin
         exp_fault = 1'b1; exp_lvl = 2'd1; tag = e1[2] ? "R4" : "R3";
      end else if (e1[1:0] == 2'd3) begin
         exp_pa = (e1 & 32'hFFC0_0000) | (va & 32'h003F_FFFF); exp_size = 2'd3;
      end else begin
         exp_reads = 2;
         if (e1[1:0] == 2'd0) a2 = (e1 & 32'hFFFF_F000) + {20'd0, va[21:12], 2'b00};
         else                 a2 = (e1 & 32'hFFFF_FC00) + {22'd0, va[21:14], 2'b00};
         if (!e2[2] || e2[1:0] == 2'd3) begin
            exp_fault = 1'b1; exp_lvl = 2'd2; tag = e2[2] ? "R4" : "R3";
         end else begin
            m = (e2[1:0] == 2'd0) ? 32'hFFFF_F000 :
                (e2[1:0] == 2'd1) ? 32'hFFFF_C000 : 32'hFFFF_0000;
            exp_pa = (e2 & m) | (va & ~m); exp_size = e2[1:0]; tag = "R8";
         end
      end

      @(negedge clk);
      chk("R9", "req_ready idle", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_va = va; req_tbl_base = base;
      @(negedge clk);
      req_valid = 1'b0; req_va = next_rand(); req_tbl_base = next_rand();
      reads = 0; guard = 0;
      while (!rsp_valid && guard < 100) begin
         guard++;
         if (mem_req_valid) begin
            reads++;
            chk(reads == 1 ? "R2" : (e1[1:0] == 2'd0 ? "R6" : "R7"), "read addr",
                mem_req_addr, reads == 1 ? a1 : a2);
            chk("R9", "req_ready busy", {31'd0, req_ready}, 32'd0);
            for (int s = 0; s < stall; s++) begin
               @(negedge clk);
               chk("R2", "held addr", {31'd0, mem_req_valid} ^ mem_req_addr,
                   32'd1 ^ (reads == 1 ? a1 : a2));
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            for (int l = 0; l < lat; l++) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = (reads == 1) ? e1 : e2;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = next_rand();
         end else begin
            @(negedge clk);
         end
      end
      chk("R10", "read count", reads, exp_reads);
      chk(tag, "fault", {31'd0, rsp_fault}, {31'd0, exp_fault});
      chk(tag, "fault level", {30'd0, rsp_fault_lvl}, {30'd0, exp_lvl});
      chk(exp_fault ? "R12" : tag, "pa", rsp_pa, exp_pa);
      chk(exp_fault ? "R12" : tag, "size", {30'd0, rsp_size}, {30'd0, exp_size});
      hold_pa = rsp_pa;
      for (int h = 0; h < stall; h++) begin
         @(negedge clk);
         chk("R9", "held result", {31'd0, rsp_valid} ^ rsp_pa, 32'd1 ^ hold_pa);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk("R9", "idle after take", {30'd0, req_ready, rsp_valid}, 32'd2);
   endtask

   initial begin
      logic [31:0] vas [6];
      rst = 1'b1; req_valid = 1'b0; req_va = '0; req_tbl_base = '0;
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; rsp_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "reset outputs", {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'd4);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "after reset", {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'd4);

      vas[0] = 32'h0000_0000; vas[1] = 32'hFFFF_FFFF;
      for (int i = 2; i < 6; i++) vas[i] = next_rand();
      for (int v = 0; v < 6; v++)
         for (int t1 = 0; t1 < 4; t1++)
            for (int p1 = 0; p1 < 2; p1++)
               for (int t2 = 0; t2 < 4; t2++)
                  for (int p2 = 0; p2 < 2; p2++) begin
                     logic [31:0] e1, e2;
                     e1 = (next_rand() & 32'hFFFF_FFF8) | {29'd0, p1[0], t1[1:0]};
                     e2 = (next_rand() & 32'hFFFF_FFF8) | {29'd0, p2[0], t2[1:0]};
                     walk(vas[v], next_rand(), e1, e2, (t2 + v) % 3, (t1 + p2) % 3);
                  end

      // R11: reset between a read and its response
      @(negedge clk);
      req_valid = 1'b1; req_va = 32'h1234_5678; req_tbl_base = 32'h0010_0000;
      @(negedge clk);
      req_valid = 1'b0;
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1", "mid-walk reset", {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'd4);
      mem_rsp_valid = 1'b1; mem_rsp_data = 32'hABC0_0007;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk("R11", "stale response ignored",
             {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'd4);
         @(negedge clk);
      end
      walk(32'h8765_4321, 32'h0020_0000, 32'h5550_0007, 32'h0, 1, 0);

      summary();
      $finish;
   end
endmodule